// File: doc/BRIEF.md
# Eight-bit bidirectional I/O port

This block is an eight-bit general-purpose I/O port seen by a host through a small register bus (address, write strobe, read strobe, 8-bit write and read data). Each pin has a direction bit and an output data latch. When a pin is an output, the block drives the latch value onto the pad. When a pin is an input, the pad driver is released and the pin level is read back through a two-flop synchronizer.

A single active-low control bit switches on weak pull-ups for every pin. The pull-up on a pin is forced off whenever that pin is configured as an output. The low five pins can be set to analog mode, and a pin in analog mode reads as zero from the port register. Whether those pins start in analog or digital mode after reset comes from a configuration input that is sampled during reset. After reset, software can change the analog/digital choice through a register.

The port read path and the latch read path are separate. Reading the port returns the synchronized pin levels. Reading the latch returns the value last written, so a read-modify-write on the latch never picks up the pin levels.

Top module: `gpio_port8`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers take their reset values. The direction register becomes all ones (every pin an input, so `pad_oe` is 0). The output latch becomes 0. The control register at address 4 becomes 0x80 (bit 7 set means pull-ups off), so `pad_pu` is 0.
- R2: The analog-select register at address 4'd3 holds bits 4:0, where 1 means analog. At reset it loads 0x1F if `cfg_low_digital` is 0, and 0x00 if it is 1. Changing `cfg_low_digital` outside reset has no effect.
- R3: A direction bit of 1 makes that pin an input (`pad_oe` bit 0). A direction bit of 0 makes it an output (`pad_oe` bit 1). `pad_out` always carries the output latch.
- R4: A read of the latch address (1) returns the latched output value, not the pin level.
- R5: A write to the port address (0) or to the latch address (1) updates the output latch at the clock edge of the write.
- R6: `pad_pu` bit i is 1 only when control bit 7 is 0 and direction bit i is 1. An output pin never has its pull-up on.
- R7: A read of the port address (0) returns the pad inputs through a two-flop synchronizer. A pin change becomes visible after the second rising edge, not after the first. Any pin in analog mode reads 0.
- R8: Only bits 4:0 of the analog-select register are writable. Bits 7:5 read back as 0, and the upper three pins never read as analog.
- R9: A write to an address from 5 to 7 changes no register. A read of such an address returns 0. `rd_data` is 0 whenever `rd_en` is low.
- R10: A read of the direction address (2) returns the direction register. A read of the control address (4) returns only bit 7, with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_low_digital | input | 1 | Sampled in reset: 1 makes pins 4:0 digital |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational, 0 when not reading |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| pad_pu | output | 8 | Weak pull-up enables, 1 = on |

## Verification
The direction register is tried with a mixed value (0xCF), all outputs and all inputs, which separates pad enable polarity errors from bit-order errors.

The latch is written through both the port and the latch address with pad inputs that differ from the latch. This shows whether the latch read path reads the latch or the pin level.

Pad inputs are tried with the pattern 0xFF and the pattern 0x81. They are checked under all-analog, all-digital and partly-analog settings, and one cycle and two cycles after a change. This pins down both the masking of the low pins and the exact synchronizer latency.

Pull-ups are checked against each combination of the global bit and the direction bits.

// File: rtl/gpio_port_pkg.sv
// Package: shared register map for the eight-bit I/O port.
// Assumes a 3-bit register address; unmapped codes are ignored.
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PORT  = 3'd0,
        A_LATCH = 3'd1,
        A_DIR   = 3'd2,
        A_ANSEL = 3'd3,
        A_CTRL  = 3'd4
    } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage input synchronizer.
// Passes each bit through STAGES flops; assumes STAGES >= 2.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the pad sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: register storage for direction, output latch, analog select
// and the global pull-up control. Assumes writes take effect on the edge
// where wr_en is high; the port and latch addresses both write the latch.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ANA_PINS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_low_digital,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [WIDTH-1:0]    wr_data,
    output logic [WIDTH-1:0]    dir_q,
    output logic [WIDTH-1:0]    latch_q,
    output logic [ANA_PINS-1:0] ansel_q,
    output logic                pu_off_q
);
    logic wr_latch, wr_dir, wr_ansel, wr_ctrl;

    // Decode which register a write targets.
    always_comb begin
        wr_latch = wr_en && (addr == A_PORT || addr == A_LATCH);
        wr_dir   = wr_en && (addr == A_DIR);
        wr_ansel = wr_en && (addr == A_ANSEL);
        wr_ctrl  = wr_en && (addr == A_CTRL);
    end

    // Direction register: all inputs out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wr_data;
    end

    // Output data latch: cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (wr_latch) latch_q <= wr_data;
    end

    // Analog select: default chosen by the configuration input during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ansel_q <= cfg_low_digital ? '0 : '1;
        else if (wr_ansel) ansel_q <= wr_data[ANA_PINS-1:0];
    end

    // Global pull-up control (1 = pull-ups off), off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       pu_off_q <= 1'b1;
        else if (wr_ctrl) pu_off_q <= wr_data[WIDTH-1];
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: pad-side control. Drives the enable from the direction bits,
// the value from the latch, and gates the pull-ups per pin.
// Assumes direction 1 = input.
module gpio_pad_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic             pu_off_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Per-pin driver enable, value and pull-up gating.
        always_comb begin
            pad_oe[i]  = ~dir_q[i];
            pad_out[i] = latch_q[i];
            pad_pu[i]  = ~pu_off_q & dir_q[i];
        end
    end
endmodule

// File: rtl/gpio_read_mux.sv
// Module: read-data selection. The port path returns synchronized pins
// with analog pins forced to zero; the latch path returns stored data.
// Assumes ANA_PINS < WIDTH and rd_data is zero without a read strobe.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ANA_PINS = 5
) (
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WIDTH-1:0]    pin_sync,
    input  logic [WIDTH-1:0]    dir_q,
    input  logic [WIDTH-1:0]    latch_q,
    input  logic [ANA_PINS-1:0] ansel_q,
    input  logic                pu_off_q,
    output logic [WIDTH-1:0]    rd_data
);
    localparam int HI_PINS = WIDTH - ANA_PINS;

    logic [WIDTH-1:0] ana_mask;
    logic [WIDTH-1:0] port_val;

    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        if (i < ANA_PINS) begin : g_ana
            assign ana_mask[i] = ansel_q[i];
        end else begin : g_dig
            assign ana_mask[i] = 1'b0;
        end
    end

    assign port_val = pin_sync & ~ana_mask;

    // Select the addressed register, or zero.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                A_PORT:  rd_data = port_val;
                A_LATCH: rd_data = latch_q;
                A_DIR:   rd_data = dir_q;
                A_ANSEL: rd_data = {{HI_PINS{1'b0}}, ansel_q};
                A_CTRL:  rd_data = {pu_off_q, {(WIDTH-1){1'b0}}};
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port8.sv
// Module: eight-bit bidirectional I/O port top. Joins the registers,
// the input synchronizer, the pad control and the read selection.
// Assumes a single clock domain for the bus; pads are asynchronous.
module gpio_port8
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ANA_PINS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_low_digital,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0]    dir_q;
    logic [WIDTH-1:0]    latch_q;
    logic [ANA_PINS-1:0] ansel_q;
    logic                pu_off_q;
    logic [WIDTH-1:0]    pin_sync;

    gpio_regs #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_low_digital(cfg_low_digital),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .dir_q(dir_q), .latch_q(latch_q), .ansel_q(ansel_q),
        .pu_off_q(pu_off_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .dir_q(dir_q), .latch_q(latch_q), .pu_off_q(pu_off_q),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    gpio_read_mux #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS)) u_rd (
        .rd_en(rd_en), .addr(addr), .pin_sync(pin_sync), .dir_q(dir_q),
        .latch_q(latch_q), .ansel_q(ansel_q), .pu_off_q(pu_off_q),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/gpio_port8_chk.sv
// Module: assertion checker for the I/O port, bound to the top module.
// Assumes synchronous active-low reset.
module gpio_port8_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ANA_PINS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic [WIDTH-1:0]    wr_data,
    input logic                rd_en,
    input logic [WIDTH-1:0]    rd_data,
    input logic [WIDTH-1:0]    pad_out,
    input logic [WIDTH-1:0]    pad_oe,
    input logic [WIDTH-1:0]    pad_pu,
    input logic [ANA_PINS-1:0] ansel_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && pad_pu == '0));

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR) |=> (pad_oe == ~$past(wr_data)));

    // R5
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_PORT || addr == A_LATCH)) |=> (pad_out == $past(wr_data)));

    // R6
    pullup_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R7
    analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_PORT) |-> ((rd_data[ANA_PINS-1:0] & ansel_q) == '0));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
endmodule

bind gpio_port8 gpio_port8_chk #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .ansel_q(ansel_q)
);

// File: tb/sim_gpio_port8.sv
// Bench: directed scenarios for the eight-bit I/O port, one task each.
module sim_gpio_port8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_low_digital = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port8 u0 (
        .clk(clk), .rst_n(rst_n), .cfg_low_digital(cfg_low_digital),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic cfg);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_low_digital = cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_now(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        read_now(a, d);
    endtask

    task automatic t_reset_analog();
        logic [7:0] d;
        pad_in = 8'hFF;
        do_reset(1'b0);
        #1;
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 pad_pu", pad_pu, 8'h00);
        do_read(3'd2, d); chk("R1 dir", d, 8'hFF);
        do_read(3'd1, d); chk("R1 latch", d, 8'h00);
        do_read(3'd4, d); chk("R1 ctrl", d, 8'h80);
        do_read(3'd3, d); chk("R2 ansel default", d, 8'h1F);
        repeat (2) @(negedge clk);
        do_read(3'd0, d); chk("R7 analog masked", d, 8'hE0);
    endtask

    task automatic t_reset_digital();
        logic [7:0] d;
        do_reset(1'b1);
        do_read(3'd3, d); chk("R2 ansel digital", d, 8'h00);
        repeat (2) @(negedge clk);
        do_read(3'd0, d); chk("R7 digital pins", d, 8'hFF);
        cfg_low_digital = 1'b0;
        repeat (2) @(negedge clk);
        do_read(3'd3, d); chk("R2 cfg ignored after reset", d, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        do_write(3'd2, 8'hCF);
        #1 chk("R3 pad_oe mixed", pad_oe, 8'h30);
        do_read(3'd2, d); chk("R10 dir readback", d, 8'hCF);
        do_write(3'd2, 8'h00);
        #1 chk("R3 pad_oe all out", pad_oe, 8'hFF);
        do_write(3'd2, 8'hFF);
        #1 chk("R3 pad_oe all in", pad_oe, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        pad_in = 8'h3C;
        do_write(3'd0, 8'hA5);
        #1 chk("R5 port addr writes latch", pad_out, 8'hA5);
        repeat (2) @(negedge clk);
        do_read(3'd1, d); chk("R4 latch not pin", d, 8'hA5);
        do_read(3'd0, d); chk("R7 port shows pins", d, 8'h3C);
        do_write(3'd1, 8'h5A);
        #1 chk("R5 latch addr writes latch", pad_out, 8'h5A);
        do_read(3'd1, d); chk("R4 latch readback", d, 8'h5A);
    endtask

    task automatic t_pullup();
        logic [7:0] d;
        do_write(3'd2, 8'hCF);
        #1 chk("R6 pu still off", pad_pu, 8'h00);
        do_write(3'd4, 8'h7F);
        #1 chk("R6 pu on inputs only", pad_pu, 8'hCF);
        do_read(3'd4, d); chk("R10 ctrl only bit7", d, 8'h00);
        do_write(3'd2, 8'h00);
        #1 chk("R6 pu off for outputs", pad_pu, 8'h00);
        do_write(3'd2, 8'hFF);
        #1 chk("R6 pu all inputs", pad_pu, 8'hFF);
        do_write(3'd4, 8'h80);
        #1 chk("R6 pu disabled", pad_pu, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] d;
        do_write(3'd3, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h81;
        @(negedge clk);
        read_now(3'd0, d); chk("R7 one edge old", d, 8'h00);
        @(negedge clk);
        read_now(3'd0, d); chk("R7 two edges new", d, 8'h81);
    endtask

    task automatic t_ansel();
        logic [7:0] d;
        pad_in = 8'hFF;
        do_write(3'd3, 8'hFF);
        do_read(3'd3, d); chk("R8 upper ansel bits", d, 8'h1F);
        do_read(3'd0, d); chk("R8 upper pins digital", d, 8'hE0);
        do_write(3'd3, 8'h0A);
        do_read(3'd0, d); chk("R8 partial analog", d, 8'hF5);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        do_write(3'd2, 8'h3C);
        do_write(3'd1, 8'h66);
        do_write(3'd7, 8'h00);
        do_write(3'd5, 8'h00);
        #1 chk("R9 pad_oe unchanged", pad_oe, 8'hC3);
        chk("R9 pad_out unchanged", pad_out, 8'h66);
        do_read(3'd3, d); chk("R9 ansel unchanged", d, 8'h0A);
        do_read(3'd4, d); chk("R9 ctrl unchanged", d, 8'h80);
        do_read(3'd6, d); chk("R9 unmapped read", d, 8'h00);
        @(negedge clk);
        addr = 3'd1; rd_en = 1'b0;
        #1 chk("R9 no strobe zero", rd_data, 8'h00);
    endtask

    initial begin
        t_reset_analog();
        t_reset_digital();
        t_direction();
        t_latch();
        t_pullup();
        t_sync();
        t_ansel();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule